// File: doc/BRIEF.md
# Keyboard Matrix Column Scanner

This block walks a key matrix one column at a time. Before each column it leaves every column released for a programmable number of idle cycles. It then drives the column low for one cycle and captures the row inputs at the end of that cycle. A row that reads low marks the key at that crossing as pressed. After the capture, the block emits one observation per configured row: a valid strobe, the key index and the pressed flag. A downstream debounce stage consumes this stream. The frame boundaries are marked with a start strobe and an end strobe. An optional gap can be inserted between frames.

The row count and the column count are programmed as the count minus one. The matrix holds up to 8 rows and 20 columns. The key index runs down the rows of a column before moving to the next column. While the block scans, it also compares each column's snapshot of pressed rows with the snapshots of the earlier columns in the same frame. If two columns have two or more pressed rows in common, that pattern is a rectangle that can hide a phantom key. In that case, when ghost detection is enabled, the block adds one extra observation that carries a reserved code before it closes the frame. An optional pull-up mode drives the just-scanned column high for one cycle after its capture. This speeds up slow rising edges.

Top module: `kscan_top`

## Requirements
- R1: During reset, and while `enable_i` is low, every column is released (`col_oe_o` all zero) and `obs_valid_o`, `frame_start_o`, `frame_end_o` and `ghost_o` stay low.
- R2: At most one column is driven low at any time (`col_oe_o[c]`=1 with `col_drive_o[c]`=0). Columns are driven in ascending order from 0 up to `col_m1_i`, and no column above `col_m1_i` is ever driven low.
- R3: Each column slot lasts `col_idle_i` idle cycles (a value of 0 counts as 1), then one drive cycle, then one observation cycle per configured row.
- R4: Each observation carries the index column×rows+row. Its pressed flag is 1 exactly when that row input was low during the column's drive cycle. The observations come out in index order, one per cycle.
- R5: The configured matrix has `row_m1_i`+1 rows and `col_m1_i`+1 columns. A frame therefore lasts from its start strobe to its end strobe inclusive, for cols×(idle+1+rows)+1 cycles, plus 1 if a ghost code is emitted.
- R6: `frame_start_o` is high for one cycle, on the first idle cycle of column 0. `frame_end_o` is high for one cycle, directly after the last observation, and never together with an observation.
- R7: When `frame_ext_en_i` is 1 and `frame_ext_cnt_i` is nonzero, 4×`frame_ext_cnt_i` idle cycles separate the end strobe from the next start strobe. Otherwise the next frame starts in the cycle right after the end strobe.
- R8: If two scanned columns in one frame share two or more pressed rows and `ghost_en_i` is 1, an extra observation with index 0xF5 and pressed flag 1 follows the last regular observation, with `ghost_o` high. The end strobe comes in the next cycle.
- R9: With `ghost_en_i` at 0, no 0xF5 observation is emitted, `ghost_o` stays low, and the frame length does not include the extra cycle.
- R10: With `pull_high_i` at 1, the cycle right after a column's drive cycle drives that column high (`col_oe_o`=1, `col_drive_o`=1). With `pull_high_i` at 0, the column is released in that cycle.
- R11: Lowering `enable_i` releases all columns and stops the observations by the next cycle. Raising it again starts a fresh frame at column 0, index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Scan clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Run the scanner |
| row_m1_i | input | 3 | Number of rows minus one |
| col_m1_i | input | 5 | Number of columns minus one |
| col_idle_i | input | 2 | Idle cycles before each column (0 acts as 1) |
| frame_ext_en_i | input | 1 | Enable the gap between frames |
| frame_ext_cnt_i | input | 7 | Gap length in units of 4 cycles |
| ghost_en_i | input | 1 | Enable rectangle detection and the 0xF5 code |
| pull_high_i | input | 1 | Drive each column high for one cycle after its scan |
| rows_i | input | 8 | Row inputs, low means pressed on the driven column |
| col_drive_o | output | 20 | Column output values |
| col_oe_o | output | 20 | Column output enables (0 means released) |
| obs_valid_o | output | 1 | Observation valid |
| obs_index_o | output | 8 | Key index, or 0xF5 for a ghost report |
| obs_pressed_o | output | 1 | Key observed pressed |
| frame_start_o | output | 1 | First cycle of a frame |
| frame_end_o | output | 1 | Frame complete |
| ghost_o | output | 1 | Ghost code on the observation stream |

## Verification
The rectangle decision for the final column and the close of the frame fall in the same cycle. The final column's snapshot is compared with the earlier ones on the clock edge that ends the column drive. The outcome must then reach the sequencer before its last row observation picks the next state. The bench provokes this by placing the second column of a pressed rectangle on the last configured column, both in a 2×2 matrix and in a 3×5 matrix. It then judges that the 0xF5 observation appears exactly between the last regular observation and the end strobe, and that the frame is one cycle longer. The same patterns with detection disabled must give the plain frame length.

// File: rtl/kscan_pkg.sv
package kscan_pkg;
  localparam int unsigned KS_MAX_ROWS = 8;
  localparam int unsigned KS_MAX_COLS = 20;
  localparam int unsigned KS_IDLE_W   = 2;
  localparam int unsigned KS_EXT_W    = 7;
  localparam logic [7:0]  KS_GHOST_CODE = 8'hF5;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_IDLE,
    ST_DRIVE,
    ST_EMIT,
    ST_GHOST,
    ST_FEND,
    ST_GAP
  } scan_st_e;
endpackage

// File: rtl/kscan_seq.sv
module kscan_seq import kscan_pkg::*; #(
  parameter int unsigned ROW_W  = 3,
  parameter int unsigned COL_W  = 5,
  parameter int unsigned IDLE_W = KS_IDLE_W,
  parameter int unsigned EXT_W  = KS_EXT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic [ROW_W-1:0]  row_last_i,
  input  logic [COL_W-1:0]  col_last_i,
  input  logic [IDLE_W-1:0] col_idle_i,
  input  logic              ext_en_i,
  input  logic [EXT_W-1:0]  ext_cnt_i,
  input  logic              ghost_pend_i,
  output scan_st_e          st_o,
  output logic [COL_W-1:0]  col_o,
  output logic [ROW_W-1:0]  row_o,
  output logic              first_o
);
  localparam int unsigned CNT_W = EXT_W + 2;

  scan_st_e         st_q;
  logic [COL_W-1:0] col_q;
  logic [ROW_W-1:0] row_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] idle_last;
  logic [CNT_W-1:0] gap_last;
  logic             gap_go;

  assign idle_last = (col_idle_i == '0) ? '0 : CNT_W'(col_idle_i) - CNT_W'(1);
  assign gap_last  = {ext_cnt_i, 2'b00} - CNT_W'(1);
  assign gap_go    = ext_en_i && (ext_cnt_i != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_OFF;
      col_q <= '0;
      row_q <= '0;
      cnt_q <= '0;
    end else if (!enable_i) begin
      st_q  <= ST_OFF;
      col_q <= '0;
      row_q <= '0;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        ST_OFF: begin
          st_q  <= ST_IDLE;
          col_q <= '0;
          cnt_q <= '0;
        end
        ST_IDLE: begin
          if (cnt_q == idle_last) begin
            st_q  <= ST_DRIVE;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        ST_DRIVE: begin
          st_q  <= ST_EMIT;
          row_q <= '0;
        end
        ST_EMIT: begin
          if (row_q == row_last_i) begin
            row_q <= '0;
            if (col_q == col_last_i) begin
              st_q <= ghost_pend_i ? ST_GHOST : ST_FEND;
            end else begin
              col_q <= col_q + COL_W'(1);
              cnt_q <= '0;
              st_q  <= ST_IDLE;
            end
          end else begin
            row_q <= row_q + ROW_W'(1);
          end
        end
        ST_GHOST: st_q <= ST_FEND;
        ST_FEND: begin
          col_q <= '0;
          cnt_q <= '0;
          st_q  <= gap_go ? ST_GAP : ST_IDLE;
        end
        ST_GAP: begin
          if (cnt_q == gap_last) begin
            cnt_q <= '0;
            st_q  <= ST_IDLE;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        default: st_q <= ST_OFF;
      endcase
    end
  end

  assign st_o    = st_q;
  assign col_o   = col_q;
  assign row_o   = row_q;
  assign first_o = (st_q == ST_IDLE) && (col_q == '0) && (cnt_q == '0);
endmodule

// File: rtl/kscan_ghost.sv
module kscan_ghost #(
  parameter int unsigned MAX_ROWS = 8,
  parameter int unsigned MAX_COLS = 20,
  parameter int unsigned COL_W    = 5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                capture_i,
  input  logic                clear_i,
  input  logic [COL_W-1:0]    col_i,
  input  logic [MAX_ROWS-1:0] snap_i,
  output logic                ghost_o
);
  logic [MAX_COLS-1:0] hit;
  logic                flag_q;

  for (genvar c = 0; c < MAX_COLS; c++) begin : g_col
    logic [MAX_ROWS-1:0] snap_q;
    logic [MAX_ROWS-1:0] both;

    assign both = snap_q & snap_i;
    // two or more shared rows with an earlier column of this frame
    assign hit[c] = (COL_W'(c) < col_i) && ((both & (both - MAX_ROWS'(1))) != '0);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              snap_q <= '0;
      else if (capture_i && col_i == COL_W'(c)) snap_q <= snap_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  flag_q <= 1'b0;
    else if (clear_i)             flag_q <= 1'b0;
    else if (capture_i && |hit)   flag_q <= 1'b1;
  end

  assign ghost_o = flag_q;
endmodule

// File: rtl/kscan_col_drv.sv
module kscan_col_drv #(
  parameter int unsigned MAX_COLS = 20,
  parameter int unsigned COL_W    = 5
) (
  input  logic                active_i,
  input  logic                pull_i,
  input  logic [COL_W-1:0]    col_i,
  output logic [MAX_COLS-1:0] drive_o,
  output logic [MAX_COLS-1:0] oe_o
);
  for (genvar c = 0; c < MAX_COLS; c++) begin : g_pin
    logic sel;
    assign sel        = (col_i == COL_W'(c));
    assign oe_o[c]    = sel & (active_i | pull_i);
    assign drive_o[c] = ~(sel & active_i);
  end
endmodule

// File: rtl/kscan_top.sv
module kscan_top import kscan_pkg::*; #(
  parameter  int unsigned MAX_ROWS = KS_MAX_ROWS,
  parameter  int unsigned MAX_COLS = KS_MAX_COLS,
  parameter  int unsigned IDLE_W   = KS_IDLE_W,
  parameter  int unsigned EXT_W    = KS_EXT_W,
  localparam int unsigned ROW_W    = $clog2(MAX_ROWS),
  localparam int unsigned COL_W    = $clog2(MAX_COLS),
  localparam int unsigned IDX_W    = $clog2(MAX_ROWS * MAX_COLS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                enable_i,
  input  logic [ROW_W-1:0]    row_m1_i,
  input  logic [COL_W-1:0]    col_m1_i,
  input  logic [IDLE_W-1:0]   col_idle_i,
  input  logic                frame_ext_en_i,
  input  logic [EXT_W-1:0]    frame_ext_cnt_i,
  input  logic                ghost_en_i,
  input  logic                pull_high_i,
  input  logic [MAX_ROWS-1:0] rows_i,
  output logic [MAX_COLS-1:0] col_drive_o,
  output logic [MAX_COLS-1:0] col_oe_o,
  output logic                obs_valid_o,
  output logic [IDX_W-1:0]    obs_index_o,
  output logic                obs_pressed_o,
  output logic                frame_start_o,
  output logic                frame_end_o,
  output logic                ghost_o
);
  scan_st_e            st;
  logic [COL_W-1:0]    col;
  logic [ROW_W-1:0]    row;
  logic                first;
  logic [COL_W-1:0]    col_last;
  logic [MAX_ROWS-1:0] row_mask;
  logic [MAX_ROWS-1:0] pressed_now;
  logic [MAX_ROWS-1:0] pressed_q;
  logic                ghost_flag;
  logic [IDX_W-1:0]    row_cnt;
  logic [IDX_W-1:0]    key_idx;

  assign col_last = (col_m1_i > COL_W'(MAX_COLS - 1)) ? COL_W'(MAX_COLS - 1) : col_m1_i;

  for (genvar r = 0; r < MAX_ROWS; r++) begin : g_mask
    assign row_mask[r] = (ROW_W'(r) <= row_m1_i);
  end

  assign pressed_now = ~rows_i & row_mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              pressed_q <= '0;
    else if (st == ST_DRIVE)  pressed_q <= pressed_now;
  end

  kscan_seq #(
    .ROW_W (ROW_W),
    .COL_W (COL_W),
    .IDLE_W(IDLE_W),
    .EXT_W (EXT_W)
  ) i_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .enable_i    (enable_i),
    .row_last_i  (row_m1_i),
    .col_last_i  (col_last),
    .col_idle_i  (col_idle_i),
    .ext_en_i    (frame_ext_en_i),
    .ext_cnt_i   (frame_ext_cnt_i),
    .ghost_pend_i(ghost_flag & ghost_en_i),
    .st_o        (st),
    .col_o       (col),
    .row_o       (row),
    .first_o     (first)
  );

  kscan_ghost #(
    .MAX_ROWS(MAX_ROWS),
    .MAX_COLS(MAX_COLS),
    .COL_W   (COL_W)
  ) i_ghost (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .capture_i(st == ST_DRIVE),
    .clear_i  ((st == ST_FEND) || (st == ST_OFF)),
    .col_i    (col),
    .snap_i   (pressed_now),
    .ghost_o  (ghost_flag)
  );

  kscan_col_drv #(
    .MAX_COLS(MAX_COLS),
    .COL_W   (COL_W)
  ) i_col_drv (
    .active_i(st == ST_DRIVE),
    .pull_i  (pull_high_i && (st == ST_EMIT) && (row == '0)),
    .col_i   (col),
    .drive_o (col_drive_o),
    .oe_o    (col_oe_o)
  );

  assign row_cnt = IDX_W'(row_m1_i) + IDX_W'(1);
  assign key_idx = IDX_W'(col) * row_cnt + IDX_W'(row);

  assign obs_valid_o   = (st == ST_EMIT) || (st == ST_GHOST);
  assign obs_index_o   = (st == ST_GHOST) ? IDX_W'(KS_GHOST_CODE) : key_idx;
  assign obs_pressed_o = (st == ST_GHOST) || ((st == ST_EMIT) && pressed_q[row]);
  assign frame_start_o = first;
  assign frame_end_o   = (st == ST_FEND);
  assign ghost_o       = (st == ST_GHOST);
endmodule

// File: rtl/kscan_chk.sv
module kscan_chk #(
  parameter int unsigned MAX_COLS = 20,
  parameter int unsigned COL_W    = 5,
  parameter int unsigned ROW_W    = 3,
  parameter int unsigned IDX_W    = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                enable_i,
  input logic [ROW_W-1:0]    row_m1_i,
  input logic [COL_W-1:0]    col_m1_i,
  input logic                frame_ext_en_i,
  input logic                ghost_en_i,
  input logic [MAX_COLS-1:0] col_drive_o,
  input logic [MAX_COLS-1:0] col_oe_o,
  input logic                obs_valid_o,
  input logic [IDX_W-1:0]    obs_index_o,
  input logic                obs_pressed_o,
  input logic                frame_start_o,
  input logic                frame_end_o,
  input logic                ghost_o
);
  assert_one_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(col_oe_o & ~col_drive_o));

  assert_col_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (col_oe_o >> (int'(col_m1_i) + 1)) == '0);

  assert_obs_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (obs_valid_o && !ghost_o) |->
      int'(obs_index_o) < (int'(col_m1_i) + 1) * (int'(row_m1_i) + 1));

  assert_end_alone_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end_o |-> (!obs_valid_o && !frame_start_o));

  assert_end_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end_o |=> !frame_end_o);

  assert_no_gap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_end_o && enable_i && !frame_ext_en_i) |=> frame_start_o);

  assert_ghost_code_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ghost_o |-> (obs_valid_o && obs_pressed_o && obs_index_o == IDX_W'(8'hF5)));

  assert_ghost_end_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ghost_o && enable_i) |=> frame_end_o);

  assert_ghost_off_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ghost_en_i |-> !ghost_o);

  assert_release_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> (col_oe_o == '0 && !obs_valid_o));
endmodule

bind kscan_top kscan_chk #(
  .MAX_COLS(MAX_COLS),
  .COL_W   (COL_W),
  .ROW_W   (ROW_W),
  .IDX_W   (IDX_W)
) i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .enable_i      (enable_i),
  .row_m1_i      (row_m1_i),
  .col_m1_i      (col_m1_i),
  .frame_ext_en_i(frame_ext_en_i),
  .ghost_en_i    (ghost_en_i),
  .col_drive_o   (col_drive_o),
  .col_oe_o      (col_oe_o),
  .obs_valid_o   (obs_valid_o),
  .obs_index_o   (obs_index_o),
  .obs_pressed_o (obs_pressed_o),
  .frame_start_o (frame_start_o),
  .frame_end_o   (frame_end_o),
  .ghost_o       (ghost_o)
);

// File: tb/test_kscan_top.sv
module test_kscan_top;
  timeunit 1ns;
  timeprecision 1ps;

  typedef struct packed {
    logic [2:0]   rm1;
    logic [4:0]   cm1;
    logic [1:0]   idle;
    logic         ext_en;
    logic [6:0]   ext_cnt;
    logic         gh_en;
    logic         pull;
    logic [159:0] keys;   // bit c*8+r set = key pressed
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{3'd3, 5'd3,  2'd3, 1'b0, 7'd0,   1'b1, 1'b1, (160'd1 << 0) | (160'd1 << 19)},
    '{3'd7, 5'd19, 2'd1, 1'b1, 7'd2,   1'b1, 1'b0, (160'd1 << 159) | (160'd1 << 5) | (160'd1 << 82)},
    '{3'd1, 5'd1,  2'd0, 1'b1, 7'd0,   1'b1, 1'b1, (160'd1 << 0) | (160'd1 << 1) | (160'd1 << 8) | (160'd1 << 9)},
    '{3'd1, 5'd1,  2'd0, 1'b0, 7'd5,   1'b0, 1'b0, (160'd1 << 0) | (160'd1 << 1) | (160'd1 << 8) | (160'd1 << 9)},
    '{3'd0, 5'd0,  2'd2, 1'b1, 7'd1,   1'b1, 1'b0, (160'd1 << 0)},
    '{3'd2, 5'd4,  2'd2, 1'b1, 7'd127, 1'b1, 1'b1, (160'd1 << 8) | (160'd1 << 10) | (160'd1 << 32) | (160'd1 << 34)},
    '{3'd2, 5'd4,  2'd2, 1'b0, 7'd0,   1'b0, 1'b1, (160'd1 << 8) | (160'd1 << 10) | (160'd1 << 32) | (160'd1 << 34)}
  };

  logic         clk = 1'b0;
  logic         rst_n;
  logic         enable;
  logic [2:0]   row_m1;
  logic [4:0]   col_m1;
  logic [1:0]   col_idle;
  logic         ext_en;
  logic [6:0]   ext_cnt;
  logic         gh_en;
  logic         pull;
  logic [7:0]   rows;
  logic [19:0]  col_drive;
  logic [19:0]  col_oe;
  logic         obs_valid;
  logic [7:0]   obs_index;
  logic         obs_pressed;
  logic         frame_start;
  logic         frame_end;
  logic         ghost;
  logic [159:0] keys;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  kscan_top i_kscan_top (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .enable_i       (enable),
    .row_m1_i       (row_m1),
    .col_m1_i       (col_m1),
    .col_idle_i     (col_idle),
    .frame_ext_en_i (ext_en),
    .frame_ext_cnt_i(ext_cnt),
    .ghost_en_i     (gh_en),
    .pull_high_i    (pull),
    .rows_i         (rows),
    .col_drive_o    (col_drive),
    .col_oe_o       (col_oe),
    .obs_valid_o    (obs_valid),
    .obs_index_o    (obs_index),
    .obs_pressed_o  (obs_pressed),
    .frame_start_o  (frame_start),
    .frame_end_o    (frame_end),
    .ghost_o        (ghost)
  );

  // matrix model: a row is pulled low through a pressed key on a low column
  always_comb begin
    rows = '1;
    for (int c = 0; c < 20; c++)
      for (int r = 0; r < 8; r++)
        if (col_oe[c] && !col_drive[c] && keys[c*8+r]) rows[r] = 1'b0;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic run_vec(input vec_t v, input int id);
    int nr, nc, ni, n, k, ec, er, pc, lowcnt, lowc, nobs;
    int obs_err, drv_err, pull_err, exp_len, exp_gap, sh;
    bit g, eg, gseen, done;
    @(negedge clk);
    enable = 1'b0; row_m1 = v.rm1; col_m1 = v.cm1; col_idle = v.idle;
    ext_en = v.ext_en; ext_cnt = v.ext_cnt; gh_en = v.gh_en; pull = v.pull;
    keys = v.keys;
    repeat (2) @(negedge clk);
    nr = int'(v.rm1) + 1; nc = int'(v.cm1) + 1;
    ni = (v.idle == 0) ? 1 : int'(v.idle);
    g = 1'b0;
    for (int c1 = 0; c1 < nc; c1++)
      for (int c2 = c1 + 1; c2 < nc; c2++) begin
        sh = 0;
        for (int r = 0; r < nr; r++) if (v.keys[c1*8+r] && v.keys[c2*8+r]) sh++;
        if (sh >= 2) g = 1'b1;
      end
    eg = g && v.gh_en;
    exp_len = nc * (ni + 1 + nr) + (eg ? 1 : 0) + 1;
    exp_gap = (v.ext_en && v.ext_cnt != 0) ? 4 * int'(v.ext_cnt) + 1 : 1;

    enable = 1'b1;
    k = 0;
    do begin @(negedge clk); k++; end while (!frame_start && k < 100);
    chk(frame_start, "R6", $sformatf("v%0d frame start seen", id), int'(frame_start), 1);

    n = 0; ec = 0; er = 0; pc = -1; nobs = 0; obs_err = 0; drv_err = 0; pull_err = 0;
    gseen = 1'b0; done = 1'b0;
    while (!done && n < 3000) begin
      n++;
      lowcnt = 0; lowc = -1;
      for (int c = 0; c < 20; c++) if (col_oe[c] && !col_drive[c]) begin lowcnt++; lowc = c; end
      if (lowcnt > 1 || (lowcnt == 1 && lowc != ec)) drv_err++;
      if (pc >= 0 && (col_oe[pc] !== v.pull || (v.pull && col_drive[pc] !== 1'b1))) pull_err++;
      pc = (lowcnt == 1) ? lowc : -1;
      if (obs_valid) begin
        if (ec < nc) begin
          if (int'(obs_index) != ec * nr + er || obs_pressed !== v.keys[ec*8+er] || ghost)
            obs_err++;
          nobs++; er++;
          if (er == nr) begin er = 0; ec++; end
        end else begin
          if (obs_index !== 8'hF5 || !obs_pressed || !ghost) obs_err++;
          gseen = 1'b1;
        end
      end
      if (frame_end) done = 1'b1;
      else @(negedge clk);
    end
    chk(n == exp_len, "R3", $sformatf("v%0d frame length (R5 sizes)", id), n, exp_len);
    chk(nobs == nc * nr, "R5", $sformatf("v%0d observation count", id), nobs, nc * nr);
    chk(obs_err == 0, "R4", $sformatf("v%0d observation mismatches", id), obs_err, 0);
    chk(drv_err == 0, "R2", $sformatf("v%0d column drive errors", id), drv_err, 0);
    chk(pull_err == 0, "R10", $sformatf("v%0d post-scan column state errors", id), pull_err, 0);
    if (v.gh_en)
      chk(gseen == eg, "R8", $sformatf("v%0d ghost code emitted", id), int'(gseen), int'(eg));
    else
      chk(!gseen, "R9", $sformatf("v%0d ghost code suppressed", id), int'(gseen), 0);

    k = 0;
    do begin @(negedge clk); k++; end while (!frame_start && k < 1000);
    chk(k == exp_gap, "R7", $sformatf("v%0d cycles from end to next start", id), k, exp_gap);
    enable = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
  end

  initial begin
    int k;
    rst_n = 1'b0; enable = 1'b0; row_m1 = 3'd3; col_m1 = 5'd3; col_idle = 2'd3;
    ext_en = 1'b0; ext_cnt = 7'd0; gh_en = 1'b1; pull = 1'b0; keys = '0;
    repeat (3) begin
      @(negedge clk);
      chk(col_oe == '0 && !obs_valid && !frame_start && !frame_end && !ghost,
          "R1", "outputs quiet in reset", int'(col_oe), 0);
    end
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(col_oe == '0 && !obs_valid && !frame_start, "R1", "outputs quiet while disabled",
        int'(col_oe), 0);

    for (int i = 0; i < NV; i++) run_vec(VECS[i], i);

    // R11: drop enable mid-frame, then restart
    @(negedge clk);
    row_m1 = 3'd3; col_m1 = 5'd3; col_idle = 2'd1; ext_en = 1'b0; gh_en = 1'b1;
    pull = 1'b0; keys = 160'd1;
    enable = 1'b1;
    k = 0;
    do begin @(negedge clk); k++; end while (!frame_start && k < 100);
    repeat (10) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    chk(col_oe == '0 && !obs_valid, "R11", "released after enable drop", int'(col_oe), 0);
    enable = 1'b1;
    k = 0;
    do begin @(negedge clk); k++; end while (!frame_start && k < 100);
    chk(frame_start, "R11", "fresh frame start", int'(frame_start), 1);
    k = 0;
    while (!obs_valid && k < 100) begin @(negedge clk); k++; end
    chk(obs_index == 8'd0 && obs_pressed, "R11", "first observation index after restart",
        int'(obs_index), 0);
    enable = 1'b0;
    repeat (2) @(negedge clk);
    summary();
  end
endmodule